// File: doc/BRIEF.md
# Edge Event Timestamp Capture

This block is the front end of one logic-analyser channel. A single asynchronous digital input is brought into the clock domain through a short synchroniser. Each transition is then qualified against a 3-bit capture mode. A qualifying transition loads the current value of a free-running timestamp counter into a one-entry output slot. The slot is drained with a valid/ready handshake. Each event also carries the input level just after the transition.

The capture modes are: any edge, rising only, falling only, and two prescaled rising modes that keep only every fourth or every sixteenth rising edge. An arm strobe starts a capture run. It records the synchronised input level so that a host can rebuild the waveform from the level plus the list of timestamps. It also restarts the prescaler, the captured-event count and the sticky overflow flag.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset `evValid`, `overflow`, `initLevel` and `eventCount` are all 0.
- R2: Mode codes are 3'd1 any edge, 3'd2 falling, 3'd3 rising, 3'd4 every fourth rising, 3'd5 every sixteenth rising. Codes 3'd0, 3'd6 and 3'd7 never produce an event.
- R3: In mode 3'd1 every transition of `sigIn` yields one event, and `evLevel` alternates from one event to the next.
- R4: Mode 3'd3 yields events only on low-to-high transitions, with `evLevel` = 1. Mode 3'd2 yields events only on high-to-low transitions, with `evLevel` = 0.
- R5: Mode 3'd4 emits on the 4th, 8th, ... rising edge and mode 3'd5 on the 16th, 32nd, ... rising edge, counted from the last arm or mode change. `evLevel` is 1.
- R6: A change of `sigIn` set up before clock edge k shows up as `evValid` after edge k+2 and not earlier. The difference between two event stamps equals the number of clock cycles between the two input transitions.
- R7: The timestamp counter is `TS_WIDTH` bits wide (16 or 32) and wraps modulo 2^TS_WIDTH, so stamp differences are taken modulo 2^TS_WIDTH.
- R8: `armPulse` latches the synchronised input level into `initLevel`. It also clears `eventCount`, `overflow` and the prescaler.
- R9: While `evValid` is 1 and `evReady` is 0, `evStamp` and `evLevel` hold. A qualifying edge that arrives while the slot is full and not being drained is dropped and sets `overflow`, which stays set until the next arm.
- R10: `eventCount` rises by one for each event loaded into the output slot. Dropped events do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | 1 | Asynchronous digital input being watched |
| modeSel | input | 3 | Capture mode code |
| armPulse | input | 1 | One-cycle strobe starting a capture run |
| evReady | input | 1 | Consumer accepts the event in the slot |
| evValid | output | 1 | Output slot holds an event |
| evStamp | output | TS_WIDTH | Timestamp of the event |
| evLevel | output | 1 | Input level just after the recorded transition |
| initLevel | output | 1 | Synchronised input level latched at arm |
| eventCount | output | CNT_WIDTH | Events loaded since the last arm |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
An input transition driven on a falling clock edge passes two synchroniser flops and then the slot register. It therefore appears at `evValid` just after the third rising edge. The bench samples one half-period later: it checks that `evValid` is still low after two edges and high after three. `initLevel`, `eventCount` and `overflow` settle one edge after the arm or drop that changes them. Their checks sample at the next falling edge. The event monitor samples a moment after each falling edge, when `evValid` and `evReady` are both stable for the following transfer edge. Stamp differences are compared against the exact number of cycles the bench placed between transitions.

// File: rtl/esc_pkg.sv
package esc_pkg;

  localparam logic [2:0] MODE_OFF    = 3'd0;
  localparam logic [2:0] MODE_ANY    = 3'd1;
  localparam logic [2:0] MODE_FALL   = 3'd2;
  localparam logic [2:0] MODE_RISE   = 3'd3;
  localparam logic [2:0] MODE_RISE4  = 3'd4;
  localparam logic [2:0] MODE_RISE16 = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // qualified edge this cycle
    logic level;      // synchronised level after the edge
    logic arm;        // start of a capture run
    logic syncLevel;  // current synchronised level
  } ctrlStb_t;

endpackage

// File: rtl/esc_ctrl.sv
module esc_ctrl
  import esc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sigIn,
  input  logic [2:0] modeSel,
  input  logic       armPulse,
  output ctrlStb_t   stb
);

  localparam int PRE_W = $clog2(DIV_HI);
  localparam logic [PRE_W-1:0] LO_LAST = PRE_W'(DIV_LO - 1);
  localparam logic [PRE_W-1:0] HI_LAST = PRE_W'(DIV_HI - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic [2:0] modeQ;
  logic [PRE_W-1:0] preCnt;

  logic level, riseEv, fallEv, preClear, preHit, capture;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= sigIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sigIn};
    end
  endgenerate

  assign level  = syncQ[SYNC_STAGES-1];
  assign riseEv = level & ~prevQ;
  assign fallEv = ~level & prevQ;
  assign preClear = armPulse | (modeSel != modeQ);

  always_comb begin
    preHit = 1'b0;
    if (!preClear && riseEv) begin
      if (modeSel == MODE_RISE4)  preHit = (preCnt == LO_LAST);
      if (modeSel == MODE_RISE16) preHit = (preCnt == HI_LAST);
    end
  end

  always_comb begin
    case (modeSel)
      MODE_ANY:                capture = riseEv | fallEv;
      MODE_FALL:               capture = fallEv;
      MODE_RISE:               capture = riseEv;
      MODE_RISE4, MODE_RISE16: capture = preHit;
      default:                 capture = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= 1'b0;
      modeQ  <= MODE_OFF;
      preCnt <= '0;
    end else begin
      prevQ <= level;
      modeQ <= modeSel;
      if (preClear || preHit)  preCnt <= '0;
      else if (riseEv)         preCnt <= preCnt + 1'b1;
    end
  end

  assign stb.capture   = capture;
  assign stb.level     = level;
  assign stb.arm       = armPulse;
  assign stb.syncLevel = level;

  // R2: unused codes never produce a capture strobe
  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (modeSel >= MODE_ANY && modeSel <= MODE_RISE16));

  // R4: falling mode events always carry a low level
  assert_fall_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && modeSel == MODE_FALL) |-> !stb.level);

  // R4 / R5: rising and prescaled events carry a high level
  assert_rise_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && modeSel >= MODE_RISE) |-> stb.level);

endmodule

// File: rtl/esc_datapath.sv
module esc_datapath
  import esc_pkg::*;
#(
  parameter int TS_WIDTH  = 32,
  parameter int CNT_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic                 evReady,
  output logic                 evValid,
  output logic [TS_WIDTH-1:0]  evStamp,
  output logic                 evLevel,
  output logic                 initLevel,
  output logic [CNT_WIDTH-1:0] eventCount,
  output logic                 overflow
);

  logic [TS_WIDTH-1:0] tsCount;
  logic slotFree, accept, drop;

  assign slotFree = !evValid || evReady;
  assign accept   = stb.capture && slotFree;
  assign drop     = stb.capture && !slotFree;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) tsCount <= '0;
    else       tsCount <= tsCount + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evValid <= 1'b0;
      evStamp <= '0;
      evLevel <= 1'b0;
    end else if (accept) begin
      evValid <= 1'b1;
      evStamp <= tsCount;
      evLevel <= stb.level;
    end else if (evReady) begin
      evValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initLevel  <= 1'b0;
      eventCount <= '0;
      overflow   <= 1'b0;
    end else if (stb.arm) begin
      initLevel  <= stb.syncLevel;
      eventCount <= CNT_WIDTH'(accept);
      overflow   <= 1'b0;
    end else begin
      eventCount <= eventCount + CNT_WIDTH'(accept);
      overflow   <= overflow | drop;
    end
  end

  // R9: stalled slot keeps its contents
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !evReady) |=> (evValid && $stable(evStamp) && $stable(evLevel)));

  // R9: overflow stays set until an arm
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !stb.arm) |=> overflow);

  // R8: arm leaves the overflow flag clear
  assert_arm_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.arm |=> !overflow);

  // R10: each loaded event adds one to the count
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !stb.arm) |=> (eventCount == CNT_WIDTH'($past(eventCount) + 1'b1)));

endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
  import esc_pkg::*;
#(
  parameter int TS_WIDTH  = 32,
  parameter int CNT_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sigIn,
  input  logic [2:0]           modeSel,
  input  logic                 armPulse,
  input  logic                 evReady,
  output logic                 evValid,
  output logic [TS_WIDTH-1:0]  evStamp,
  output logic                 evLevel,
  output logic                 initLevel,
  output logic [CNT_WIDTH-1:0] eventCount,
  output logic                 overflow
);

  ctrlStb_t stb;

  esc_ctrl #(.SYNC_STAGES(2), .DIV_LO(4), .DIV_HI(16)) u_ctrl (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .modeSel(modeSel),
    .armPulse(armPulse), .stb(stb)
  );

  esc_datapath #(.TS_WIDTH(TS_WIDTH), .CNT_WIDTH(CNT_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .evReady(evReady),
    .evValid(evValid), .evStamp(evStamp), .evLevel(evLevel),
    .initLevel(initLevel), .eventCount(eventCount), .overflow(overflow)
  );

endmodule

// File: tb/edge_stamp_capture_tb.sv
module edge_stamp_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TSW = 16;
  localparam int CW  = 16;

  typedef struct packed {
    logic [2:0] mode;
    logic [7:0] pulses;
    logic [7:0] expEv;
    logic       expLast;
    logic [7:0] gap;
  } vec_t;

  // rising edges every 8 cycles, each level held 4 cycles
  localparam vec_t VECS [10] = '{
    '{3'd1, 8'd3,  8'd6, 1'b0, 8'd4},
    '{3'd3, 8'd3,  8'd3, 1'b1, 8'd8},
    '{3'd2, 8'd3,  8'd3, 1'b0, 8'd8},
    '{3'd4, 8'd9,  8'd2, 1'b1, 8'd32},
    '{3'd5, 8'd33, 8'd2, 1'b1, 8'd128},
    '{3'd0, 8'd5,  8'd0, 1'b0, 8'd0},
    '{3'd6, 8'd5,  8'd0, 1'b0, 8'd0},
    '{3'd7, 8'd5,  8'd0, 1'b0, 8'd0},
    '{3'd4, 8'd3,  8'd0, 1'b0, 8'd0},
    '{3'd5, 8'd16, 8'd1, 1'b1, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigIn = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic armPulse = 1'b0;
  logic evReady = 1'b1;
  logic evValid, evLevel, initLevel, overflow;
  logic [TSW-1:0] evStamp;
  logic [CW-1:0] eventCount;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [TSW-1:0] logStamp [256];
  logic logLevel [256];
  int totalEv = 0;

  edge_stamp_capture #(.TS_WIDTH(TSW), .CNT_WIDTH(CW)) u_dut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .modeSel(modeSel),
    .armPulse(armPulse), .evReady(evReady), .evValid(evValid),
    .evStamp(evStamp), .evLevel(evLevel), .initLevel(initLevel),
    .eventCount(eventCount), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // records every transfer that the next rising edge performs
  always @(negedge clk) begin
    #1;
    if (rstN && evValid && evReady) begin
      logStamp[totalEv[7:0]] = evStamp;
      logLevel[totalEv[7:0]] = evLevel;
      totalEv = totalEv + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doArm();
    armPulse = 1'b1;
    waitN(1);
    armPulse = 1'b0;
    waitN(1);
  endtask

  task automatic pulse();
    sigIn = 1'b1;
    waitN(4);
    sigIn = 1'b0;
    waitN(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [TSW-1:0] s1;
    waitN(3);
    // R1 reset state
    check(evValid == 1'b0, "R1 evValid", evValid, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    check(eventCount == '0, "R1 eventCount", eventCount, 0);
    check(initLevel == 1'b0, "R1 initLevel", initLevel, 0);
    rstN = 1'b1;
    waitN(4);
    check(evValid == 1'b0 && eventCount == '0, "R1 idle after release", evValid, 0);

    // vector table: modes R2 R3 R4 R5, spacing R6, count R10
    foreach (VECS[i]) begin
      modeSel = VECS[i].mode;
      waitN(4);
      doArm();
      check(initLevel == 1'b0, "R8 initLevel low", initLevel, 0);
      base = totalEv;
      for (int p = 0; p < int'(VECS[i].pulses); p++) pulse();
      waitN(6);
      check(totalEv - base == int'(VECS[i].expEv), "R2/R5 event count per mode", totalEv - base, VECS[i].expEv);
      check(eventCount == CW'(VECS[i].expEv), "R10 eventCount", eventCount, VECS[i].expEv);
      if (VECS[i].expEv != 0 && totalEv - base == int'(VECS[i].expEv))
        check(logLevel[8'(base + int'(VECS[i].expEv) - 1)] == VECS[i].expLast, "R4 last level",
              logLevel[8'(base + int'(VECS[i].expEv) - 1)], VECS[i].expLast);
      for (int k = base + 1; k < totalEv; k++)
        check(TSW'(logStamp[8'(k)] - logStamp[8'(k-1)]) == TSW'(VECS[i].gap), "R6 stamp spacing",
              TSW'(logStamp[8'(k)] - logStamp[8'(k-1)]), VECS[i].gap);
      if (VECS[i].mode == 3'd1)
        for (int k = base; k < totalEv; k++)
          check(logLevel[8'(k)] == ((k - base) % 2 == 0), "R3 alternating level",
                logLevel[8'(k)], (k - base) % 2 == 0);
    end

    // R8: arm latches a high level
    modeSel = 3'd0;
    sigIn = 1'b1;
    waitN(4);
    doArm();
    check(initLevel == 1'b1, "R8 initLevel high", initLevel, 1);
    sigIn = 1'b0;
    waitN(4);

    // R6 latency, R9 hold and drop
    modeSel = 3'd1;
    evReady = 1'b0;
    waitN(4);
    doArm();
    sigIn = 1'b1;
    waitN(2);
    check(evValid == 1'b0, "R6 not before third edge", evValid, 0);
    waitN(1);
    check(evValid == 1'b1, "R6 valid after third edge", evValid, 1);
    check(evLevel == 1'b1, "R3 rising level", evLevel, 1);
    s1 = evStamp;
    waitN(5);
    check(evValid == 1'b1 && evStamp == s1, "R9 stamp held", evStamp, s1);
    sigIn = 1'b0;
    waitN(5);
    check(overflow == 1'b1, "R9 overflow set on drop", overflow, 1);
    check(eventCount == CW'(1), "R10 dropped not counted", eventCount, 1);
    check(evStamp == s1 && evLevel == 1'b1, "R9 slot untouched by drop", evStamp, s1);
    evReady = 1'b1;
    waitN(1);
    check(evValid == 1'b0, "R9 drained", evValid, 0);
    waitN(3);
    check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);
    doArm();
    check(overflow == 1'b0 && eventCount == '0, "R8 arm clears", overflow, 0);

    // R7 wrap: rising edges 65546 cycles apart
    modeSel = 3'd3;
    waitN(4);
    doArm();
    base = totalEv;
    sigIn = 1'b1;
    waitN(4);
    sigIn = 1'b0;
    waitN(65542);
    sigIn = 1'b1;
    waitN(4);
    sigIn = 1'b0;
    waitN(6);
    check(totalEv - base == 2, "R7 two events", totalEv - base, 2);
    check(TSW'(logStamp[8'(base+1)] - logStamp[8'(base)]) == TSW'(10), "R7 wrapped spacing",
          TSW'(logStamp[8'(base+1)] - logStamp[8'(base)]), 10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule